// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block takes in a card-to-reader answer whose length the reader already knows. The card's answer carries no start marker, stop marker or length field. A thresholded subcarrier level comes in, and the block counts its transitions inside fixed windows to decide each bit. A window that holds roughly the edge count of a running subcarrier is a 1 bit. A quiet window, or one with far too many or too few edges, is a 0 bit.

The reader pulses `arm` when its own frame ends. At that moment the block latches the requested bit count and a keystream mask that was computed ahead of time. It then lets a fixed response delay pass and measures back-to-back windows. Time is counted in ticks from an external enable. When the last window closes, the block XORs the word it collected with the latched mask and presents the result with a one-cycle `done`.

A card that answers with only zeros looks the same as an absent card, so the block never reports presence or absence.

Top module: `subcarrier_edge_rx`

## Requirements
- R1: After reset, `data_out` is 0 and `done` is 0.
- R2: `sc_in` passes through two flops before it is used. On every cycle with `tick` high, the synchronised level is compared with the level taken at the previous tick, and a difference counts as one edge. Level changes between two ticks that cancel out are not counted.
- R3: No edges are counted during the first RESP_DELAY ticks that follow the arm cycle. A tick in the arm cycle itself does not count toward this delay. The first window starts with tick RESP_DELAY+1.
- R4: Each bit window is WIN_TICKS ticks long, and the windows follow each other with no gap.
- R5: A window gives a 1 bit when its edge count is strictly greater than BAND_LO and strictly less than BAND_HI. Every other count gives a 0 bit.
- R6: The bit from window j is placed at bit position j of the word, so the first bit received is the least significant bit.
- R7: A `bit_count` above WORD_W is treated as WORD_W. A `bit_count` of 0 gives `done` at the end of the response delay, with `data_out` equal to the mask.
- R8: The final word is the collected bits XOR the `key_mask` value sampled in the arm cycle. Changes on `key_mask` after the arm cycle have no effect on the result.
- R9: `done` is high for exactly one cycle. It rises at the clock edge that processes the final tick of the last window, which is tick RESP_DELAY + n*WIN_TICKS after arm. `data_out` changes only in that cycle and in the cycle after an arm.
- R10: An arm clears `data_out` to 0 on the next clock edge. An arm during a reception abandons that reception and starts a new one.
- R11: Cycles with `tick` low do not advance the delay or the windows, and no edges are counted in them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable; one tick per high cycle |
| arm | input | 1 | Start strobe, given when the reader frame ends |
| bit_count | input | CNT_W | Number of bits to receive |
| key_mask | input | WORD_W | Keystream mask, latched at arm |
| sc_in | input | 1 | Thresholded subcarrier level (asynchronous) |
| data_out | output | WORD_W | Received word after unmasking |
| done | output | 1 | One-cycle pulse when the word is ready |

## Verification
The bench builds the block with RESP_DELAY=30, WIN_TICKS=24, BAND_LO=4 and BAND_HI=12, and keeps WORD_W=32. These values make a full 32-bit frame short, so one run can include clamped, zero-length, restarted and tick-gated frames. The narrow band lets the stimulus place 4, 5, 11 and 12 edges in chosen windows, which puts both band edges on either side of the decision. It also lets a window toggle on every tick and produce 24 edges, well above the band.

// File: rtl/subcarrier_edge_rx.sv
module subcarrier_edge_rx #(
  parameter int WORD_W     = 32,
  parameter int CNT_W      = 6,
  parameter int RESP_DELAY = 490,
  parameter int WIN_TICKS  = 150,
  parameter int BAND_LO    = 20,
  parameter int BAND_HI    = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              arm,
  input  logic [CNT_W-1:0]  bit_count,
  input  logic [WORD_W-1:0] key_mask,
  input  logic              sc_in,
  output logic [WORD_W-1:0] data_out,
  output logic              done
);
  localparam int TMAX = (RESP_DELAY > WIN_TICKS) ? RESP_DELAY : WIN_TICKS;
  localparam int TW = (TMAX > 1) ? $clog2(TMAX) : 1;
  localparam int EW = $clog2(WIN_TICKS + 1);
  localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int NW = $clog2(WORD_W + 1);
  localparam logic [TW-1:0] DLY_LAST = TW'(RESP_DELAY - 1);
  localparam logic [TW-1:0] WIN_LAST = TW'(WIN_TICKS - 1);
  localparam logic [1:0] IDLE = 2'd0, WAITD = 2'd1, RECV = 2'd2;

  logic              s1, s2, lvl_q;
  logic [1:0]        st_q;
  logic [TW-1:0]     tcnt;
  logic [EW-1:0]     ecnt;
  logic [BW-1:0]     bidx;
  logic [NW-1:0]     n_q;
  logic [WORD_W-1:0] mask_q, word_q;

  wire              edge_now  = tick & (s2 ^ lvl_q);
  wire [EW-1:0]     ecnt_nxt  = ecnt + EW'(edge_now);
  wire              bit_one   = (int'(ecnt_nxt) > BAND_LO) && (int'(ecnt_nxt) < BAND_HI);
  wire [WORD_W-1:0] word_nxt  = word_q | (WORD_W'(bit_one) << bidx);
  wire              last_bit  = (NW'(bidx) + NW'(1)) == n_q;
  wire [NW-1:0]     n_clamped = (int'(bit_count) > WORD_W) ? NW'(WORD_W) : NW'(bit_count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      lvl_q <= 1'b0;
      st_q <= IDLE;
      tcnt <= '0;
      ecnt <= '0;
      bidx <= '0;
      n_q <= '0;
      mask_q <= '0;
      word_q <= '0;
      data_out <= '0;
      done <= 1'b0;
    end else begin
      s1 <= sc_in;
      s2 <= s1;
      if (tick) lvl_q <= s2;
      done <= 1'b0;
      if (arm) begin
        st_q <= WAITD;
        n_q <= n_clamped;
        mask_q <= key_mask;
        word_q <= '0;
        data_out <= '0;
        tcnt <= '0;
        ecnt <= '0;
        bidx <= '0;
      end else if (tick) begin
        case (st_q)
          WAITD: begin
            if (tcnt == DLY_LAST) begin
              tcnt <= '0;
              if (n_q == '0) begin
                data_out <= mask_q;
                done <= 1'b1;
                st_q <= IDLE;
              end else begin
                st_q <= RECV;
              end
            end else begin
              tcnt <= tcnt + TW'(1);
            end
          end
          RECV: begin
            if (tcnt == WIN_LAST) begin
              tcnt <= '0;
              ecnt <= '0;
              word_q <= word_nxt;
              if (last_bit) begin
                data_out <= word_nxt ^ mask_q;
                done <= 1'b1;
                st_q <= IDLE;
              end else begin
                bidx <= bidx + BW'(1);
              end
            end else begin
              tcnt <= tcnt + TW'(1);
              ecnt <= ecnt_nxt;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/subcarrier_edge_rx_chk.sv
module subcarrier_edge_rx_chk #(
  parameter int WORD_W    = 32,
  parameter int WIN_TICKS = 150,
  parameter int EW        = 8,
  parameter int NW        = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              done,
  input logic [WORD_W-1:0] data_out,
  input logic [1:0]        st,
  input logic [EW-1:0]     ecnt,
  input logic [NW-1:0]     n_q
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !arm |=> (done || $stable(data_out))); // R9
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) arm |=> (data_out == '0 && !done)); // R10
  AST_DONE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(st) != 2'd0); // R9
  AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(ecnt) <= WIN_TICKS); // R4
  AST_COUNT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n) int'(n_q) <= WORD_W); // R7
endmodule

bind subcarrier_edge_rx subcarrier_edge_rx_chk #(
  .WORD_W(WORD_W), .WIN_TICKS(WIN_TICKS), .EW(EW), .NW(NW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .done(done), .data_out(data_out),
  .st(st_q), .ecnt(ecnt), .n_q(n_q)
);

// File: tb/subcarrier_edge_rx_test.sv
`timescale 1ns/1ps
module subcarrier_edge_rx_test;
  localparam int D = 30, W = 24, LO = 4, HI = 12, WW = 32;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, arm = 1'b0, sc_in = 1'b0;
  logic [5:0] bit_count = '0;
  logic [WW-1:0] key_mask = '0;
  wire [WW-1:0] data_out;
  wire done;

  int vectors = 0, miscompares = 0, cyc = 0;
  int ed_tab [32];

  subcarrier_edge_rx #(.WORD_W(WW), .CNT_W(6), .RESP_DELAY(D), .WIN_TICKS(W),
    .BAND_LO(LO), .BAND_HI(HI)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(arm), .bit_count(bit_count),
    .key_mask(key_mask), .sc_in(sc_in), .data_out(data_out), .done(done));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference
  int m_st, m_t, m_e, m_b, m_n, m_lvl;
  bit [31:0] m_mask, m_word, m_data;
  bit m_done;
  int hist[$];

  always @(posedge clk) begin
    int smp, ed, ec, bt;
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_e = 0; m_b = 0; m_n = 0; m_lvl = 0;
      m_mask = 0; m_word = 0; m_data = 0; m_done = 0;
      hist = {0, 0};
    end else begin
      smp = hist[0];
      ed = (tick && smp != m_lvl) ? 1 : 0;
      if (tick) m_lvl = smp;
      m_done = 0;
      if (arm) begin
        m_n = (bit_count > 32) ? 32 : int'(bit_count);
        m_mask = key_mask; m_word = 0; m_data = 0;
        m_st = 1; m_t = 0; m_e = 0; m_b = 0;
      end else if (tick && m_st == 1) begin
        if (m_t == D - 1) begin
          m_t = 0;
          if (m_n == 0) begin m_data = m_mask; m_done = 1; m_st = 0; end
          else m_st = 2;
        end else m_t++;
      end else if (tick && m_st == 2) begin
        ec = m_e + ed;
        if (m_t == W - 1) begin
          bt = (ec > LO && ec < HI) ? 1 : 0;
          if (bt == 1) m_word[m_b] = 1'b1;
          m_e = 0; m_t = 0;
          if (m_b == m_n - 1) begin m_data = m_word ^ m_mask; m_done = 1; m_st = 0; end
          else m_b++;
        end else begin
          m_e = ec; m_t++;
        end
      end
      void'(hist.pop_front());
      hist.push_back(int'(sc_in));
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R9 per-cycle done", {31'b0, done}, {31'b0, m_done});
      check("R6 per-cycle data_out", data_out, m_data);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic frame(input int n, input logic [31:0] mask, input string tag);
    int nn = (n > 32) ? 32 : n;
    logic [31:0] expw = '0, got = '0;
    int done_c = -1;
    int c;
    for (int j = 0; j < nn; j++)
      if (ed_tab[j] > LO && ed_tab[j] < HI) expw[j] = 1'b1;
    expw ^= mask;
    @(negedge clk);
    arm = 1'b1; bit_count = 6'(n); key_mask = mask; tick = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    key_mask = ~mask;
    check({tag, " R10 arm clears data_out"}, data_out, 32'h0);
    c = 1;
    while (c <= D + nn * W + 2) begin
      int pos;
      if (done && done_c < 0) begin done_c = c - 1; got = data_out; end
      pos = c + 2 - (D + 1);
      if (pos >= 0 && (pos / W) < nn && (pos % W) < ed_tab[pos / W]) sc_in = ~sc_in;
      @(negedge clk);
      c++;
    end
    check({tag, " R3 R4 done tick"}, 32'(done_c), 32'(D + nn * W));
    check({tag, " R8 word"}, got, expw);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset data_out", data_out, 32'h0);
    check("R1 reset done", {31'b0, done}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 band edges: 0,5,11,12,4,24,6,3 edges -> 0,1,1,0,0,0,1,0
    ed_tab = '{default: 0};
    ed_tab[0] = 0; ed_tab[1] = 5; ed_tab[2] = 11; ed_tab[3] = 12;
    ed_tab[4] = 4; ed_tab[5] = 24; ed_tab[6] = 6; ed_tab[7] = 3;
    frame(8, 32'h0, "R5 band");

    // R6 first and last of 12 bits set
    ed_tab = '{default: 0};
    ed_tab[0] = 8; ed_tab[11] = 8;
    frame(12, 32'h0000_0A5C, "R6 lsb-first");

    // R7 clamp 40 -> 32, odd windows carry a subcarrier
    for (int j = 0; j < 32; j++) ed_tab[j] = (j % 2 == 1) ? 8 : 0;
    frame(40, 32'h1357_9BDF, "R7 clamp");

    // R7 zero-length frame
    ed_tab = '{default: 0};
    frame(0, 32'h1234_5678, "R7 zero");

    // R2 all-ones with full mask
    for (int j = 0; j < 32; j++) ed_tab[j] = 8;
    frame(32, 32'hFFFF_FFFF, "R2 full");

    // R10 restart mid-reception
    @(negedge clk);
    arm = 1'b1; bit_count = 6'd5; key_mask = 32'hDEAD_BEEF; tick = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    for (int k = 0; k < 60; k++) begin
      sc_in = ~sc_in;
      @(negedge clk);
      check("R10 no done before restart", {31'b0, done}, 32'h0);
    end
    ed_tab = '{default: 0};
    ed_tab[1] = 7; ed_tab[2] = 9;
    frame(3, 32'h0, "R10 restart");

    // R11 tick every other cycle, sc_in toggling each cycle
    begin
      int c = 0, done_c = -1;
      logic [31:0] got = '0;
      @(negedge clk);
      arm = 1'b1; bit_count = 6'd2; key_mask = 32'h0000_00C3; tick = 1'b0;
      @(negedge clk);
      arm = 1'b0;
      c = 1;
      while (c <= 2 * (D + 2 * W) + 4) begin
        if (done && done_c < 0) begin done_c = c - 1; got = data_out; end
        tick = (c % 2 == 0);
        sc_in = ~sc_in;
        @(negedge clk);
        c++;
      end
      check("R11 gated done cycle", 32'(done_c), 32'(2 * (D + 2 * W)));
      check("R11 R2 gated word", got, 32'h0000_00C3);
    end

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule